// File: doc/BRIEF.md
# Back-EMF Stall Detector

This block watches the back-EMF level of a running stepper motor and decides whether the rotor has stalled. The analog front end is outside the block. It delivers each back-EMF reading as a digital code on `sampleIn`, and it pulses `zeroCross` at each coil current zero crossing. A programmable delay after every zero-crossing strobe picks the instant at which a reading is taken. A reading counts only when the motor is cruising at its top speed, a programmed number of full steps has passed since the ramp ended, and the drive is not being vetoed for running at full PWM duty.

Each accepted reading is tested three ways. It is compared with a fixed absolute floor. It is also compared with a band above and below a moving average of recent readings. Each test that fails sets its own sticky flag, and a combined stall flag follows them. When the motor is executing a positioning move, a stall also sets a sticky step-loss flag and sends a one-cycle hard-stop request to the position controller. All flags stay set until a status read clears them.

Top module: `bemf_stall_top`

## Requirements
- R1: When an accepted reading plus the delta threshold is strictly below the current average, and the average window is full, `stallDeltaLo` is set.
- R2: When an accepted reading is strictly above the current average plus the delta threshold, and the average window is full, `stallDeltaHi` is set.
- R3: When an accepted reading is strictly below the absolute threshold, `stallAbs` is set.
- R4: `stallAny` always equals the OR of `stallDeltaLo`, `stallDeltaHi` and `stallAbs`.
- R5: The absolute threshold is `absIdx*ABS_STEP` and the delta threshold is `delIdx*DEL_STEP`. An index of 0 disables its own test. When both indices are 0, no reading is accepted at all.
- R6: A reading is taken exactly `DLY_UNIT*(delaySel+2)` clock edges after the edge that samples `zeroCross` high. A new strobe during the wait restarts the wait.
- R7: Readings are accepted only while `phase` is 2 (constant speed; 0 idle, 1 accelerating, 3 decelerating) and at least `armSteps` `fullStep` pulses have arrived since `phase` became 2.
- R8: While `fullDutyEn` and `dutyFull` are both high, no reading is accepted.
- R9: A stall detected while `positioning` is high sets the sticky `stepLoss` flag and raises `hardStopReq` for exactly one cycle. With `positioning` low, neither happens.
- R10: Every flag holds until a cycle with `statusRd` high clears it. A new detection in that same cycle wins over the clear.
- R11: The average is floor(sum/2^AVG_LOG2) of the last 2^AVG_LOG2 accepted readings, taken before the new reading joins. The history is emptied whenever detection is not armed, and the delta tests wait until it is full again.
- R12: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| zeroCross | input | 1 | Coil current zero-crossing strobe |
| sampleIn | input | SAMPLE_W | Back-EMF reading code |
| phase | input | 2 | Motion phase: 0 idle, 1 accel, 2 constant, 3 decel |
| fullStep | input | 1 | One pulse per full step |
| dutyFull | input | 1 | PWM currently at 100% duty |
| positioning | input | 1 | A positioning move is in progress |
| statusRd | input | 1 | Status read; clears all flags |
| absIdx | input | 4 | Absolute threshold index |
| delIdx | input | 4 | Delta threshold index |
| delaySel | input | 3 | Sample delay select |
| armSteps | input | 3 | Extra full steps before arming |
| fullDutyEn | input | 1 | Enables the full-duty veto |
| stallDeltaLo | output | 1 | Sticky: reading below average band |
| stallDeltaHi | output | 1 | Sticky: reading above average band |
| stallAbs | output | 1 | Sticky: reading below absolute floor |
| stallAny | output | 1 | Sticky combined stall flag |
| stepLoss | output | 1 | Sticky step-loss flag |
| hardStopReq | output | 1 | One-cycle internal hard-stop request |

## Verification
The bench builds the block with a four-reading average window, so the delta tests come into play after only four readings, and boundary averages can be worked out by hand. Threshold steps of 8 and 4 codes keep the sample values small. A delay unit of two cycles makes the shortest wait four edges and the longest eighteen. With these values the bench can check the exact sampling edge, a restarted wait, arming after a given number of full steps, and a sequence of readings that lands just inside and just outside each band.

// File: rtl/bemf_stall_pkg.sv
package bemf_stall_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ACCEL = 2'd1,
    PH_CONST = 2'd2,
    PH_DECEL = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;     // accept sampleIn this edge
    logic restart;  // empty the average history
    logic clear;    // status read
  } ctrl_s;
endpackage

// File: rtl/bemf_stall_ctrl.sv
module bemf_stall_ctrl
  import bemf_stall_pkg::*;
#(
  parameter int DLY_UNIT = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       zeroCross,
  input  logic [1:0] phase,
  input  logic       fullStep,
  input  logic       dutyFull,
  input  logic       statusRd,
  input  logic [3:0] absIdx,
  input  logic [3:0] delIdx,
  input  logic [2:0] delaySel,
  input  logic [2:0] armSteps,
  input  logic       fullDutyEn,
  output ctrl_s      strobe
);
  localparam int MAX_DLY = DLY_UNIT * 9;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic [CNT_W-1:0] dlyLimit;
  logic [CNT_W-1:0] dlyCnt;
  logic             dlyBusy;
  logic [2:0]       stepCnt;
  logic             inConst, armed, enabled, veto, expire;

  assign dlyLimit = CNT_W'(DLY_UNIT * (int'(delaySel) + 2));
  assign inConst  = (phase_e'(phase) == PH_CONST);
  assign armed    = inConst && (stepCnt >= armSteps);
  assign enabled  = (absIdx != 4'd0) || (delIdx != 4'd0);
  assign veto     = fullDutyEn && dutyFull;
  assign expire   = dlyBusy && (dlyCnt == '0);

  // sample delay timer, restarted by every zero crossing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyBusy <= 1'b0;
      dlyCnt  <= '0;
    end else if (zeroCross) begin
      dlyBusy <= 1'b1;
      dlyCnt  <= dlyLimit - CNT_W'(1);
    end else if (expire) begin
      dlyBusy <= 1'b0;
    end else if (dlyBusy) begin
      dlyCnt  <= dlyCnt - CNT_W'(1);
    end
  end

  // full steps counted since constant speed began, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              stepCnt <= '0;
    else if (!inConst)                      stepCnt <= '0;
    else if (fullStep && stepCnt < armSteps) stepCnt <= stepCnt + 3'd1;
  end

  assign strobe.take    = expire && !zeroCross && armed && enabled && !veto;
  assign strobe.restart = !armed;
  assign strobe.clear   = statusRd;
endmodule

// File: rtl/bemf_stall_dp.sv
module bemf_stall_dp
  import bemf_stall_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int AVG_LOG2 = 3,
  parameter int ABS_STEP = 16,
  parameter int DEL_STEP = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_s               strobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                positioning,
  input  logic [3:0]          absIdx,
  input  logic [3:0]          delIdx,
  output logic                stallDeltaLo,
  output logic                stallDeltaHi,
  output logic                stallAbs,
  output logic                stallAny,
  output logic                stepLoss,
  output logic                hardStopReq
);
  localparam int DEPTH = 1 << AVG_LOG2;
  localparam int SUM_W = SAMPLE_W + AVG_LOG2;
  localparam int CMP_W = SUM_W + 8;

  logic [SAMPLE_W-1:0] win [DEPTH];
  logic [SUM_W-1:0]    sum;
  logic [AVG_LOG2:0]   fillCnt;
  logic                full;
  logic [CMP_W-1:0]    samp, avg, absThr, delThr;
  logic                hitLo, hitHi, hitAbs, hitAny;

  assign full   = (fillCnt == (AVG_LOG2 + 1)'(DEPTH));
  assign samp   = CMP_W'(sampleIn);
  assign avg    = CMP_W'(sum >> AVG_LOG2);
  assign absThr = CMP_W'(absIdx) * CMP_W'(ABS_STEP);
  assign delThr = CMP_W'(delIdx) * CMP_W'(DEL_STEP);
  assign hitLo  = (delIdx != 4'd0) && full && (samp + delThr < avg);
  assign hitHi  = (delIdx != 4'd0) && full && (samp > avg + delThr);
  assign hitAbs = (absIdx != 4'd0) && (samp < absThr);
  assign hitAny = hitLo || hitHi || hitAbs;

  // history window, newest in slot 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               win[0] <= '0;
    else if (strobe.restart) win[0] <= '0;
    else if (strobe.take)    win[0] <= sampleIn;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               win[i] <= '0;
      else if (strobe.restart) win[i] <= '0;
      else if (strobe.take)    win[i] <= win[i-1];
    end
  end

  // running sum; emptied slots hold zero so the oldest is always subtracted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sum     <= '0;
      fillCnt <= '0;
    end else if (strobe.restart) begin
      sum     <= '0;
      fillCnt <= '0;
    end else if (strobe.take) begin
      sum <= sum + SUM_W'(sampleIn) - SUM_W'(win[DEPTH-1]);
      if (!full) fillCnt <= fillCnt + (AVG_LOG2 + 1)'(1);
    end
  end

  // sticky flags: a new detection beats a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallDeltaLo <= 1'b0;
      stallDeltaHi <= 1'b0;
      stallAbs     <= 1'b0;
      stallAny     <= 1'b0;
      stepLoss     <= 1'b0;
      hardStopReq  <= 1'b0;
    end else begin
      stallDeltaLo <= (stallDeltaLo && !strobe.clear) || (strobe.take && hitLo);
      stallDeltaHi <= (stallDeltaHi && !strobe.clear) || (strobe.take && hitHi);
      stallAbs     <= (stallAbs && !strobe.clear) || (strobe.take && hitAbs);
      stallAny     <= (stallAny && !strobe.clear) || (strobe.take && hitAny);
      stepLoss     <= (stepLoss && !strobe.clear) || (strobe.take && hitAny && positioning);
      hardStopReq  <= strobe.take && hitAny && positioning;
    end
  end
endmodule

// File: rtl/bemf_stall_top.sv
module bemf_stall_top
  import bemf_stall_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int AVG_LOG2 = 3,
  parameter int ABS_STEP = 16,
  parameter int DEL_STEP = 8,
  parameter int DLY_UNIT = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                zeroCross,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [1:0]          phase,
  input  logic                fullStep,
  input  logic                dutyFull,
  input  logic                positioning,
  input  logic                statusRd,
  input  logic [3:0]          absIdx,
  input  logic [3:0]          delIdx,
  input  logic [2:0]          delaySel,
  input  logic [2:0]          armSteps,
  input  logic                fullDutyEn,
  output logic                stallDeltaLo,
  output logic                stallDeltaHi,
  output logic                stallAbs,
  output logic                stallAny,
  output logic                stepLoss,
  output logic                hardStopReq
);
  ctrl_s strobe;

  bemf_stall_ctrl #(.DLY_UNIT(DLY_UNIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .zeroCross(zeroCross), .phase(phase),
    .fullStep(fullStep), .dutyFull(dutyFull), .statusRd(statusRd),
    .absIdx(absIdx), .delIdx(delIdx), .delaySel(delaySel),
    .armSteps(armSteps), .fullDutyEn(fullDutyEn), .strobe(strobe)
  );

  bemf_stall_dp #(
    .SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2),
    .ABS_STEP(ABS_STEP), .DEL_STEP(DEL_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .positioning(positioning), .absIdx(absIdx), .delIdx(delIdx),
    .stallDeltaLo(stallDeltaLo), .stallDeltaHi(stallDeltaHi),
    .stallAbs(stallAbs), .stallAny(stallAny), .stepLoss(stepLoss),
    .hardStopReq(hardStopReq)
  );
endmodule

// File: rtl/bemf_stall_chk.sv
module bemf_stall_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] phase,
  input logic       dutyFull,
  input logic       fullDutyEn,
  input logic       statusRd,
  input logic [3:0] absIdx,
  input logic       stallDeltaLo,
  input logic       stallDeltaHi,
  input logic       stallAbs,
  input logic       stallAny,
  input logic       stepLoss,
  input logic       hardStopReq
);
  p_any_or_r4: assert property (@(posedge clk) disable iff (!rstN)
    stallAny == (stallDeltaLo || stallDeltaHi || stallAbs));

  p_sticky_abs_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stallAbs && !statusRd) |=> stallAbs);

  p_sticky_lo_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stallDeltaLo && !statusRd) |=> stallDeltaLo);

  p_sticky_hi_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stallDeltaHi && !statusRd) |=> stallDeltaHi);

  p_stop_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    hardStopReq |=> !hardStopReq);

  p_stop_steploss_r9: assert property (@(posedge clk) disable iff (!rstN)
    hardStopReq |-> stepLoss);

  p_armed_phase_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallAny) |-> ($past(phase) == 2'd2));

  p_veto_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallAny) |-> !$past(fullDutyEn && dutyFull));

  p_abs_enabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallAbs) |-> ($past(absIdx) != 4'd0));
endmodule

bind bemf_stall_top bemf_stall_chk u_chk (
  .clk(clk), .rstN(rstN), .phase(phase), .dutyFull(dutyFull),
  .fullDutyEn(fullDutyEn), .statusRd(statusRd), .absIdx(absIdx),
  .stallDeltaLo(stallDeltaLo), .stallDeltaHi(stallDeltaHi),
  .stallAbs(stallAbs), .stallAny(stallAny), .stepLoss(stepLoss),
  .hardStopReq(hardStopReq)
);

// File: tb/tb_bemf_stall_top.sv
`timescale 1ns/1ps
module tb_bemf_stall_top;
  localparam int DLY_UNIT = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       zeroCross = 1'b0;
  logic [7:0] sampleIn = 8'd0;
  logic [1:0] phase = 2'd2;
  logic       fullStep = 1'b0;
  logic       dutyFull = 1'b0;
  logic       positioning = 1'b0;
  logic       statusRd = 1'b0;
  logic [3:0] absIdx = 4'd2;
  logic [3:0] delIdx = 4'd2;
  logic [2:0] delaySel = 3'd0;
  logic [2:0] armSteps = 3'd0;
  logic       fullDutyEn = 1'b0;
  logic       stallDeltaLo, stallDeltaHi, stallAbs, stallAny, stepLoss, hardStopReq;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bemf_stall_top #(
    .SAMPLE_W(8), .AVG_LOG2(2), .ABS_STEP(8), .DEL_STEP(4), .DLY_UNIT(DLY_UNIT)
  ) dut (.*);

  // {sample, lo, hi, abs}; absolute floor 16, delta band 8, window of 4
  localparam int NVEC = 11;
  localparam logic [10:0] VEC [NVEC] = '{
    {8'd100, 3'b000}, {8'd100, 3'b000}, {8'd100, 3'b000}, {8'd100, 3'b000},
    {8'd91,  3'b100}, {8'd106, 3'b010}, {8'd10,  3'b101}, {8'd84,  3'b000},
    {8'd16,  3'b100}, {8'd62,  3'b000}, {8'd51,  3'b000}
  };

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire(input logic [7:0] v);
    sampleIn = v;
    zeroCross = 1'b1;
    @(negedge clk);
    zeroCross = 1'b0;
    repeat (DLY_UNIT * (int'(delaySel) + 2)) @(negedge clk);
  endtask

  task automatic clearFlags();
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  task automatic restartWin();
    phase = 2'd0;
    @(negedge clk);
    phase = 2'd2;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 flags", {stallDeltaLo, stallDeltaHi, stallAbs, stallAny, stepLoss, hardStopReq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R11 table walk
    for (int i = 0; i < NVEC; i++) begin
      fire(VEC[i][10:3]);
      chk($sformatf("R1 lo vec%0d", i), stallDeltaLo, VEC[i][2]);
      chk($sformatf("R2 hi vec%0d", i), stallDeltaHi, VEC[i][1]);
      chk($sformatf("R3 abs vec%0d", i), stallAbs, VEC[i][0]);
      chk($sformatf("R4 any vec%0d", i), stallAny, |VEC[i][2:0]);
      clearFlags();
    end

    // R11 history emptied when disarmed: deltas wait for a full window
    restartWin();
    fire(8'd100);
    fire(8'd20);
    chk("R11 not full", stallDeltaLo, 0);

    // R6 exact sample edge and restart
    restartWin();
    delaySel = 3'd3;
    fire(8'd5);
    chk("R6 taken late sel", stallAbs, 1);
    clearFlags();
    sampleIn = 8'd5;
    zeroCross = 1'b1; @(negedge clk); zeroCross = 1'b0;
    repeat (DLY_UNIT * 5 - 1) @(negedge clk);
    chk("R6 not early", stallAbs, 0);
    @(negedge clk);
    chk("R6 on time", stallAbs, 1);
    clearFlags();
    zeroCross = 1'b1; @(negedge clk); zeroCross = 1'b0;
    repeat (4) @(negedge clk);
    zeroCross = 1'b1; @(negedge clk); zeroCross = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 restarted", stallAbs, 0);
    repeat (4) @(negedge clk);
    chk("R6 after restart", stallAbs, 1);
    clearFlags();
    delaySel = 3'd0;

    // R7 arming
    armSteps = 3'd2;
    phase = 2'd1;
    fire(8'd5);
    chk("R7 accel", stallAny, 0);
    phase = 2'd2;
    fire(8'd5);
    chk("R7 zero steps", stallAny, 0);
    fullStep = 1'b1; @(negedge clk); fullStep = 1'b0;
    fire(8'd5);
    chk("R7 one step", stallAny, 0);
    fullStep = 1'b1; @(negedge clk); fullStep = 1'b0;
    fire(8'd5);
    chk("R7 armed", stallAbs, 1);
    clearFlags();
    phase = 2'd3;
    fire(8'd5);
    chk("R7 decel", stallAny, 0);
    phase = 2'd2;
    armSteps = 3'd0;
    @(negedge clk);

    // R8 full-duty veto
    fullDutyEn = 1'b1; dutyFull = 1'b1;
    fire(8'd5);
    chk("R8 vetoed", stallAny, 0);
    fullDutyEn = 1'b0;
    fire(8'd5);
    chk("R8 veto off", stallAbs, 1);
    clearFlags();
    dutyFull = 1'b0;

    // R5 index scaling and disable
    restartWin();
    absIdx = 4'd0;
    fire(8'd5);
    chk("R5 abs off", stallAbs, 0);
    absIdx = 4'd15;
    fire(8'd119);
    chk("R5 below 120", stallAbs, 1);
    clearFlags();
    fire(8'd120);
    chk("R5 at 120", stallAbs, 0);
    absIdx = 4'd0; delIdx = 4'd0;
    fire(8'd0);
    chk("R5 all off", stallAny, 0);
    absIdx = 4'd2; delIdx = 4'd2;

    // R9 hard stop and step loss
    restartWin();
    positioning = 1'b1;
    fire(8'd5);
    chk("R9 stop req", hardStopReq, 1);
    chk("R9 step loss", stepLoss, 1);
    @(negedge clk);
    chk("R9 one cycle", hardStopReq, 0);
    chk("R10 steploss held", stepLoss, 1);
    clearFlags();
    chk("R10 steploss cleared", stepLoss, 0);
    positioning = 1'b0;
    fire(8'd5);
    chk("R9 idle no req", hardStopReq, 0);
    chk("R9 idle no loss", stepLoss, 0);
    chk("R9 idle abs", stallAbs, 1);

    // R10 sticky, clear, set beats clear
    repeat (20) @(negedge clk);
    chk("R10 held", stallAbs, 1);
    fire(8'd50);
    chk("R10 held after good", stallAbs, 1);
    clearFlags();
    chk("R10 cleared", stallAny, 0);
    sampleIn = 8'd5;
    zeroCross = 1'b1; @(negedge clk); zeroCross = 1'b0;
    repeat (DLY_UNIT * 2 - 1) @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    chk("R10 set wins", stallAbs, 1);

    finishRun();
  end
endmodule